// File: doc/BRIEF.md
# Framed Narrow-to-Wide Word Packer

This block gathers a framed stream of narrow words into wide words. Narrow words arrive on a ready/valid input port that also carries a first-word flag and a last-word flag. Wide words leave on a ready/valid output port with the same two flags. The output also carries a bit count that says how much of the wide word holds message content. A message may be shorter than one wide word, longer than one, or carry no content at all, and the receiver always sees where it begins and ends.

Two parameters set the size: `IN_W`, the narrow word width, and `WORDS`, the number of narrow words in one wide word. The wide word is `IN_W*WORDS` bits. The bit count is `$clog2(IN_W*WORDS)+1` bits, so it can hold every value from zero up to the full width. A single output register is the only storage past the collecting accumulator. Backpressure from the output reaches the input directly.

Top module: `msg_s2p_packer`

## Requirements
- R1: A word moves on a port only in a cycle where that port's valid and ready are both high. While `out_valid` is high and `out_ready` is low, every output field holds its value into the next cycle.
- R2: `out_size` is `$clog2(IN_W*WORDS)+1` bits wide. It equals the number of narrow words in the output word times `IN_W`, and it never exceeds `IN_W*WORDS`.
- R3: `out_start` is set only on the first output word of a message and `out_stop` only on its last. An output word that is both the first and the last of its message has both flags set.
- R4: The first narrow word of a message, and the first narrow word after each emitted wide word, goes in bits `[IN_W-1:0]`. Each later word goes into the next higher `IN_W`-bit slot. Bits above `out_size` are zero.
- R5: A message longer than `WORDS` narrow words is split over several output words. Every output word with `out_stop` low reports `out_size == IN_W*WORDS`.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low.
- R7: A narrow word that arrives outside a message with `in_start` low is accepted and discarded. It produces no output word.
- R8: A word with `in_start` high that arrives inside a message closes the partial word and starts a new message with this word. The closing word carries `out_stop` set, and `out_start` set only if it is also the first output word of the old message. If no narrow word has been collected since the last emitted word, the closing word has `out_size` 0 and zero data. The new message follows in order.
- R9: After reset no message is in progress, `out_valid` is low and `in_ready` is high.
- R10: While `out_ready` stays high and no restart is in progress, `in_ready` stays high. Narrow words then move on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Narrow word offered |
| in_ready | output | 1 | Narrow word will be taken |
| in_data | input | IN_W | Narrow word content |
| in_start | input | 1 | First word of a message |
| in_stop | input | 1 | Last word of a message |
| out_valid | output | 1 | Wide word offered |
| out_ready | input | 1 | Downstream takes the wide word |
| out_data | output | IN_W*WORDS | Wide word content, first word in the low slot |
| out_start | output | 1 | First output word of a message |
| out_stop | output | 1 | Last output word of a message |
| out_size | output | $clog2(IN_W*WORDS)+1 | Count of used bits |

## Verification
The bench sweeps every message length from one to beyond two wide words. It runs each length with the output always ready and again under random output stalls and input gaps. A design that places words in the wrong slot, fails to split long messages, or leaves a stale full size on the last piece shows up as a mismatch against the arithmetically predicted stream. Targeted sequences cover four more cases. A stray unflagged word must not make a phantom output word. A restart right after a full wide word must yield an empty closing word of size zero. A restart whose new word is itself a whole message needs a second, deferred output word, so a design that dropped it or swapped the order would lose the new message. Under stalls, an input that kept accepting while the output was held, or an output that changed while held, is caught cycle by cycle.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

    // What the collector does with the narrow word in this cycle
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,   // no transfer on the input port
        ACT_DROP    = 2'd1,   // stray word outside a message
        ACT_APPEND  = 2'd2,   // word starts or continues a message
        ACT_RESTART = 2'd3    // new start inside an open message
    } s2p_act_e;

    // Width of a bit count able to hold 0..out_w inclusive
    function automatic int size_field_w(input int out_w);
        return $clog2(out_w) + 1;
    endfunction

    // Width of a word count able to hold 0..words inclusive
    function automatic int count_field_w(input int words);
        return (words < 2) ? 1 : $clog2(words + 1);
    endfunction

endpackage

// File: rtl/s2p_frame_classify.sv
module s2p_frame_classify
    import s2p_pkg::*;
(
    input  logic     fire,
    input  logic     active,
    input  logic     start,
    output s2p_act_e act
);

    always_comb begin
        if (!fire)
            act = ACT_IDLE;
        else if (!active && !start)
            act = ACT_DROP;
        else if (active && start)
            act = ACT_RESTART;
        else
            act = ACT_APPEND;
    end

endmodule

// File: rtl/s2p_collect.sv
module s2p_collect
    import s2p_pkg::*;
#(
    parameter int IN_W  = 4,
    parameter int WORDS = 3,
    localparam int OUT_W = IN_W * WORDS,
    localparam int SZ_W  = size_field_w(OUT_W),
    localparam int CNT_W = count_field_w(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  s2p_act_e         act,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_stop,
    input  logic             out_free,
    output logic             emit,
    output logic [OUT_W-1:0] emit_data,
    output logic             emit_start,
    output logic             emit_stop,
    output logic [SZ_W-1:0]  emit_size,
    output logic             pend,
    output logic             active
);

    logic [OUT_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             first_q;
    logic             pend_stop_q;

    logic [OUT_W-1:0] base_acc, new_acc;
    logic [CNT_W-1:0] base_cnt, new_cnt;
    logic             base_first;
    logic             done;

    logic [OUT_W-1:0] nx_acc;
    logic [CNT_W-1:0] nx_cnt;
    logic             nx_first, nx_active, nx_pend, nx_pend_stop;

    function automatic logic [SZ_W-1:0] bits_of(input logic [CNT_W-1:0] c);
        return SZ_W'(int'(c) * IN_W);
    endfunction

    // Starting point for the incoming word: continue or begin afresh
    always_comb begin
        if (act == ACT_APPEND && active) begin
            base_acc   = acc_q;
            base_cnt   = cnt_q;
            base_first = first_q;
        end else begin
            base_acc   = '0;
            base_cnt   = '0;
            base_first = 1'b1;
        end
    end

    // Insert the narrow word into its slot
    always_comb begin
        new_acc = base_acc;
        for (int k = 0; k < WORDS; k++) begin
            if (CNT_W'(k) == base_cnt)
                new_acc[k*IN_W +: IN_W] = in_data;
        end
        new_cnt = base_cnt + CNT_W'(1);
        done    = in_stop || (new_cnt == CNT_W'(WORDS));
    end

    always_comb begin
        emit         = 1'b0;
        emit_data    = '0;
        emit_start   = 1'b0;
        emit_stop    = 1'b0;
        emit_size    = '0;
        nx_acc       = acc_q;
        nx_cnt       = cnt_q;
        nx_first     = first_q;
        nx_active    = active;
        nx_pend      = pend;
        nx_pend_stop = pend_stop_q;
        unique case (act)
            ACT_RESTART: begin
                // close what is open, hold the new word back
                emit         = 1'b1;
                emit_data    = acc_q;
                emit_start   = first_q;
                emit_stop    = 1'b1;
                emit_size    = bits_of(cnt_q);
                nx_acc       = new_acc;
                nx_cnt       = new_cnt;
                nx_first     = 1'b1;
                nx_active    = 1'b1;
                nx_pend      = done;
                nx_pend_stop = in_stop;
            end
            ACT_APPEND: begin
                if (done) begin
                    emit      = 1'b1;
                    emit_data = new_acc;
                    emit_start = base_first;
                    emit_stop = in_stop;
                    emit_size = bits_of(new_cnt);
                    nx_acc    = '0;
                    nx_cnt    = '0;
                    nx_first  = 1'b0;
                    nx_active = !in_stop;
                end else begin
                    nx_acc    = new_acc;
                    nx_cnt    = new_cnt;
                    nx_first  = base_first;
                    nx_active = 1'b1;
                end
            end
            ACT_IDLE: begin
                if (pend && out_free) begin
                    emit       = 1'b1;
                    emit_data  = acc_q;
                    emit_start = first_q;
                    emit_stop  = pend_stop_q;
                    emit_size  = bits_of(cnt_q);
                    nx_acc     = '0;
                    nx_cnt     = '0;
                    nx_first   = 1'b0;
                    nx_active  = !pend_stop_q;
                    nx_pend    = 1'b0;
                end
            end
            default: ;  // ACT_DROP: state untouched
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q       <= '0;
            cnt_q       <= '0;
            first_q     <= 1'b0;
            active      <= 1'b0;
            pend        <= 1'b0;
            pend_stop_q <= 1'b0;
        end else begin
            acc_q       <= nx_acc;
            cnt_q       <= nx_cnt;
            first_q     <= nx_first;
            active      <= nx_active;
            pend        <= nx_pend;
            pend_stop_q <= nx_pend_stop;
        end
    end

endmodule

// File: rtl/s2p_out_stage.sv
module s2p_out_stage #(
    parameter int OUT_W = 12,
    parameter int SZ_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OUT_W-1:0] ld_data,
    input  logic             ld_start,
    input  logic             ld_stop,
    input  logic [SZ_W-1:0]  ld_size,
    input  logic             out_ready,
    output logic             free,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_start,
    output logic             out_stop,
    output logic [SZ_W-1:0]  out_size
);

    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_start <= 1'b0;
            out_stop  <= 1'b0;
            out_size  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
            out_start <= ld_start;
            out_stop  <= ld_stop;
            out_size  <= ld_size;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/msg_s2p_packer.sv
module msg_s2p_packer
    import s2p_pkg::*;
#(
    parameter int IN_W  = 4,
    parameter int WORDS = 3,
    localparam int OUT_W = IN_W * WORDS,
    localparam int SZ_W  = size_field_w(OUT_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_start,
    input  logic             in_stop,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_start,
    output logic             out_stop,
    output logic [SZ_W-1:0]  out_size
);

    s2p_act_e         act;
    logic             out_free, pend, active, fire;
    logic             emit, emit_start, emit_stop;
    logic [OUT_W-1:0] emit_data;
    logic [SZ_W-1:0]  emit_size;

    assign in_ready = out_free && !pend;
    assign fire     = in_valid && in_ready;

    s2p_frame_classify u_classify (
        .fire   (fire),
        .active (active),
        .start  (in_start),
        .act    (act)
    );

    s2p_collect #(.IN_W(IN_W), .WORDS(WORDS)) u_collect (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .in_data    (in_data),
        .in_stop    (in_stop),
        .out_free   (out_free),
        .emit       (emit),
        .emit_data  (emit_data),
        .emit_start (emit_start),
        .emit_stop  (emit_stop),
        .emit_size  (emit_size),
        .pend       (pend),
        .active     (active)
    );

    s2p_out_stage #(.OUT_W(OUT_W), .SZ_W(SZ_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (emit),
        .ld_data   (emit_data),
        .ld_start  (emit_start),
        .ld_stop   (emit_stop),
        .ld_size   (emit_size),
        .out_ready (out_ready),
        .free      (out_free),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_start (out_start),
        .out_stop  (out_stop),
        .out_size  (out_size)
    );

endmodule

// File: rtl/s2p_checker.sv
module s2p_checker #(
    parameter int IN_W  = 4,
    parameter int WORDS = 3,
    localparam int OUT_W = IN_W * WORDS,
    localparam int SZ_W  = $clog2(OUT_W) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             out_start,
    input logic             out_stop,
    input logic [SZ_W-1:0]  out_size
);

    // R1: a held output word keeps every field
    a_r1_hold_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_start) && $stable(out_stop) && $stable(out_size)));

    // R2: bit count within range and a multiple of the narrow width
    a_r2_size_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_size <= SZ_W'(OUT_W)) && ((out_size % SZ_W'(IN_W)) == '0));

    // R4: nothing above the used bits
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data >> out_size) == '0));

    // R5: every piece but the last is full
    a_r5_nonlast_full: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_stop) |-> (out_size == SZ_W'(OUT_W)));

    // R6: input blocked while the output is stalled
    a_r6_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

bind msg_s2p_packer s2p_checker #(.IN_W(IN_W), .WORDS(WORDS)) u_s2p_checker (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_start (out_start),
    .out_stop  (out_stop),
    .out_size  (out_size)
);

// File: tb/test_msg_s2p_packer.sv
module test_msg_s2p_packer;

    localparam int IN_W  = 4;
    localparam int WORDS = 3;
    localparam int OUT_W = IN_W * WORDS;
    localparam int SZ_W  = $clog2(OUT_W) + 1;

    typedef struct packed {
        logic [OUT_W-1:0] d;
        logic             s;
        logic             p;
        logic [SZ_W-1:0]  z;
    } owrd_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [IN_W-1:0]  in_data = '0;
    logic             in_start = 1'b0;
    logic             in_stop = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [OUT_W-1:0] out_data;
    logic             out_start;
    logic             out_stop;
    logic [SZ_W-1:0]  out_size;

    int n_chk  = 0;
    int n_fail = 0;

    bit stall_on = 0;
    bit gap_on   = 0;
    bit r10_on   = 0;
    logic [15:0] lfsr_o = 16'hACE1;
    logic [15:0] lfsr_i = 16'h1D2B;

    owrd_t exp_q[$];

    // reference model state
    bit               m_active = 0;
    int               m_cnt    = 0;
    logic [OUT_W-1:0] m_acc    = '0;
    bit               m_first  = 0;

    always #2 clk = ~clk;

    msg_s2p_packer #(.IN_W(IN_W), .WORDS(WORDS)) i_msg_s2p_packer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_start  (in_start),
        .in_stop   (in_stop),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_start (out_start),
        .out_stop  (out_stop),
        .out_size  (out_size)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [OUT_W-1:0] d, input bit s, input bit p, input int cnt);
        owrd_t w;
        w.d = d;
        w.s = s;
        w.p = p;
        w.z = SZ_W'(cnt * IN_W);
        exp_q.push_back(w);
    endtask

    // arithmetic expectation for one accepted narrow word
    task automatic model_word(input logic [IN_W-1:0] d, input bit s, input bit p);
        if (!m_active && !s) return;              // R7: discarded
        if (m_active && s) begin                  // R8: close partial word
            push_exp(m_acc, m_first, 1'b1, m_cnt);
            m_active = 0;
        end
        if (s) begin
            m_acc = '0; m_cnt = 0; m_first = 1; m_active = 1;
        end
        m_acc[m_cnt*IN_W +: IN_W] = d;
        m_cnt++;
        if (p || m_cnt == WORDS) begin
            push_exp(m_acc, m_first, p, m_cnt);
            m_acc = '0; m_cnt = 0; m_first = 0; m_active = !p;
        end
    endtask

    // called at a falling edge; returns at the next falling edge after acceptance
    task automatic send(input logic [IN_W-1:0] d, input bit s, input bit p);
        if (gap_on) begin
            int g;
            g = int'(lfsr_i[1:0]) % 3;
            lfsr_i = {lfsr_i[14:0], lfsr_i[15] ^ lfsr_i[13] ^ lfsr_i[12] ^ lfsr_i[10]};
            in_valid = 1'b0;
            repeat (g) @(negedge clk);
        end
        model_word(d, s, p);
        in_valid = 1'b1;
        in_data  = d;
        in_start = s;
        in_stop  = p;
        forever begin
            #1;
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic send_msg(input int len, input int seed);
        for (int i = 0; i < len; i++)
            send(IN_W'(seed * 7 + i * 5 + 3), i == 0, i == len - 1);
    endtask

    task automatic drain;
        int k = 0;
        while (exp_q.size() != 0 && k < 500) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3", "output words missing", exp_q.size(), 0);
    endtask

    // output side: ready pattern and per-cycle checks
    bit               held = 0;
    logic [OUT_W-1:0] h_d;
    logic             h_s, h_p;
    logic [SZ_W-1:0]  h_z;

    initial begin
        forever begin
            @(negedge clk);
            out_ready = stall_on ? (lfsr_o[1:0] != 2'b00) : 1'b1;
            lfsr_o = {lfsr_o[14:0], lfsr_o[15] ^ lfsr_o[13] ^ lfsr_o[12] ^ lfsr_o[10]};
            #1;
            if (rst) begin
                held = 0;
                continue;
            end
            if (held) begin
                check(out_valid && out_data == h_d && out_start == h_s &&
                      out_stop == h_p && out_size == h_z, "R1", "held word changed",
                      {out_valid, out_start, out_stop, out_size, out_data},
                      {1'b1, h_s, h_p, h_z, h_d});
            end
            if (out_valid && !out_ready) begin
                check(!in_ready, "R6", "in_ready during stall", in_ready, 0);
                held = 1;
                h_d = out_data; h_s = out_start; h_p = out_stop; h_z = out_size;
            end else begin
                held = 0;
            end
            if (r10_on)
                check(in_ready, "R10", "in_ready with open output", in_ready, 1);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7", "unexpected output word", out_data, 0);
                end else begin
                    owrd_t e;
                    e = exp_q.pop_front();
                    check(out_data == e.d, "R4", "data", out_data, e.d);
                    check(out_start == e.s && out_stop == e.p, "R3", "start/stop",
                          {out_start, out_stop}, {e.s, e.p});
                    if (e.z == '0)
                        check(out_size == e.z, "R8", "empty size", out_size, e.z);
                    else if (!e.p)
                        check(out_size == e.z, "R5", "non-last size", out_size, e.z);
                    else
                        check(out_size == e.z, "R2", "size", out_size, e.z);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid, "R9", "out_valid in reset", out_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!out_valid, "R9", "out_valid after reset", out_valid, 0);
        check(in_ready, "R9", "in_ready after reset", in_ready, 1);
        @(negedge clk);

        // always-ready output, back-to-back input: every length
        r10_on = 1;
        for (int len = 1; len <= 3 * WORDS; len++)
            send_msg(len, len);
        drain();
        r10_on = 0;

        // stalls and gaps over the same lengths
        stall_on = 1;
        gap_on   = 1;
        for (int rep = 0; rep < 3; rep++)
            for (int len = 1; len <= 3 * WORDS; len++)
                send_msg(len, len + 11 * rep);
        drain();

        // R7: stray words outside a message
        send(4'hA, 0, 0);
        send(4'h5, 0, 1);
        drain();
        #1;
        check(!out_valid, "R7", "stray word produced output", out_valid, 0);
        @(negedge clk);
        send_msg(2, 40);
        send(4'h9, 0, 0);                          // stray right after stop
        send_msg(1, 41);
        drain();

        // R8: restart inside a message, various fill levels
        for (int pre = 1; pre <= 2 * WORDS; pre++) begin
            for (int i = 0; i < pre; i++)
                send(IN_W'(pre + i), i == 0, 0);
            send(IN_W'(pre + 9), 1, 0);             // restart, continues
            send(IN_W'(pre + 2), 0, 1);
            for (int i = 0; i < pre; i++)
                send(IN_W'(pre * 3 + i), i == 0, 0);
            send(IN_W'(pre + 6), 1, 1);             // restart with one-word message
            drain();
        end

        stall_on = 0;
        gap_on   = 0;
        // restart right after a full wide word: empty closing word
        for (int i = 0; i < WORDS; i++)
            send(IN_W'(i + 1), i == 0, 0);
        send(4'hF, 1, 1);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule